// File: doc/BRIEF.md
# Gate Command Edge-Pulse Transmitter

This block conditions two logic-level PWM commands, channel A and channel B, for a half-bridge gate driver that is coupled through signal transformers. It does not pass a level across the isolation barrier. Instead, each qualified command edge becomes one narrow pulse of fixed width. A rising edge produces a pulse on the channel's rise line, and a falling edge produces a pulse on its fall line. The secondary side rebuilds the level from these pulses.

Each command first passes a per-channel stability filter. A new level is accepted only after it has stayed stable for `filt_len` clock cycles. An interlock follows the filter and gives channel A priority. Next comes a dead-time stage that holds off a channel's rise until both conditioned commands have been low for long enough. Two lockout inputs force both commands low: one for under-voltage and one for over-voltage. While the power converter is in startup, both commands are forced low and all four transmit lines are blanked.

Top module: `gate_pulse_tx`

## Requirements
- R1: A command level that holds for fewer than `max(filt_len,1)` consecutive sampling edges produces no transmit pulse on that channel. A `filt_len` of 0 behaves as 1.
- R2: Take a command level that holds for at least `max(filt_len,1)` sampling edges, on an idle block. Its rise pulse becomes visible after `max(filt_len,1)+2` clock edges, counted from the first edge that samples the new level.
- R3: A rising edge of a conditioned command drives that channel's rise line high for exactly `PULSE_CYC` cycles. A falling edge does the same on its fall line. Each edge gives exactly one pulse.
- R4: A channel's rise and fall lines are never high in the same cycle. When an edge arrives during a pulse, the running pulse ends and a full `PULSE_CYC` pulse starts on the line for the new edge. A command that stays high for W cycles, with W below `PULSE_CYC`, therefore gives a rise pulse of W cycles.
- R5: The two conditioned commands are never high together. When filtered A is high, B is forced low, and B's rise is not transmitted while A is high.
- R6: Suppose one channel's request arrives while the other conditioned command is still high. The two commands are then kept apart by exactly `dead_len+1` cycles. This is seen as that same distance between the start of the falling channel's fall pulse and the start of the rising channel's rise pulse.
- R7: When the two commands have already been low together for more than `dead_len` cycles, no extra delay is added. The rise latency is as given in R2.
- R8: While `uv_lock` or `ov_lock` is high, both commands are held low. A channel that was high gives one fall pulse, and no rise pulse is sent. When the lock is released, a command that is still high is sent again as a rise pulse.
- R9: While `conv_startup` is high, all four transmit lines are low in the same cycle and the commands are held low. When startup ends with a command still high, one rise pulse is sent.
- R10: During reset and directly after it, all four transmit lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_a | input | 1 | Channel A PWM command (has priority) |
| cmd_b | input | 1 | Channel B PWM command |
| uv_lock | input | 1 | Under-voltage lockout; forces both commands low |
| ov_lock | input | 1 | Over-voltage lockout; forces both commands low |
| conv_startup | input | 1 | Converter in startup; forces commands low and blanks the transmit lines |
| filt_len | input | FILT_W | Stability count of the glitch filter, in cycles |
| dead_len | input | DEAD_W | Minimum dead time; the actual gap is dead_len+1 cycles |
| txa_rise | output | 1 | Channel A rising-edge pulse |
| txa_fall | output | 1 | Channel A falling-edge pulse |
| txb_rise | output | 1 | Channel B rising-edge pulse |
| txb_fall | output | 1 | Channel B falling-edge pulse |

## Verification
The assertions check several properties on every cycle. Per channel, the rise and fall lines are exclusive, and the two conditioned commands are exclusive. A conditioned command never rises in the cycle in which the other one fell. A lockout clears both commands one cycle later, startup clears the pulse registers, and the filter output only ever moves toward a level the input showed. The bench scenarios add what a property cannot show:
- the exact reject/pass boundary as filt_len and pulse width are swept,
- the measured pulse widths and latencies,
- the dead-time distance as dead_len is swept,
- the absence of added delay after a long gap,
- the single fall and single rise pulses around a lockout or startup.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  // Effective stability count of the filter; zero is treated as one.
  function automatic int eff_len(input int len);
    return (len < 1) ? 1 : len;
  endfunction

  // True once the filter has seen the differing level long enough.
  function automatic bit filt_done(input int run, input int len);
    return (run + 1) >= eff_len(len);
  endfunction

  // True once the idle gap satisfies the programmed dead time.
  function automatic bit gap_met(input int gap, input int dead);
    return gap >= dead;
  endfunction
endpackage

// File: rtl/gpt_glitch_filter.sv
module gpt_glitch_filter
  import gpt_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          din,
  input  logic [CW-1:0] len,
  output logic          dout
);
  logic [CW-1:0] run_q;
  logic          differs;
  logic          accept;

  assign differs = (din != dout);
  assign accept  = differs && filt_done(int'(run_q), int'(len));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout  <= 1'b0;
      run_q <= '0;
    end else if (!differs || accept) begin
      run_q <= '0;
      if (accept) dout <= din;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  AST_FILT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout) |-> (dout == $past(din))); // R1
endmodule

// File: rtl/gpt_interlock_dead.sv
module gpt_interlock_dead
  import gpt_pkg::*;
#(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fa,
  input  logic          fb,
  input  logic          hold,
  input  logic [DW-1:0] dead_len,
  output logic          oa,
  output logic          ob
);
  localparam logic [DW-1:0] GAP_MAX = '1;

  logic [DW-1:0] gap_q;
  logic          req_a;
  logic          req_b;
  logic          gap_ok;

  assign req_a  = fa && !hold;
  assign req_b  = fb && !fa && !hold;
  assign gap_ok = gap_met(int'(gap_q), int'(dead_len));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oa    <= 1'b0;
      ob    <= 1'b0;
      gap_q <= GAP_MAX;
    end else begin
      oa <= req_a && (oa || (!ob && gap_ok));
      ob <= req_b && (ob || (!oa && gap_ok));
      if (oa || ob)              gap_q <= '0;
      else if (gap_q != GAP_MAX) gap_q <= gap_q + 1'b1;
    end
  end

  AST_CMD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(oa && ob)); // R5
  AST_DEAD_A: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ob) |-> !oa); // R6
  AST_DEAD_B: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oa) |-> !ob); // R6
  AST_LOCK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (!oa && !ob)); // R8
endmodule

// File: rtl/gpt_edge_pulser.sv
module gpt_edge_pulser #(
  parameter int PULSE_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd,
  input  logic blank,
  output logic rise_o,
  output logic fall_o
);
  localparam int PW = $clog2(PULSE_CYC + 1);
  localparam logic [PW-1:0] LOAD = PW'(PULSE_CYC - 1);

  logic          prev_q;
  logic          pos_q;
  logic          neg_q;
  logic [PW-1:0] left_q;
  logic          up_evt;
  logic          dn_evt;

  assign up_evt = cmd && !prev_q;
  assign dn_evt = !cmd && prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pos_q  <= 1'b0;
      neg_q  <= 1'b0;
      left_q <= '0;
    end else begin
      prev_q <= cmd;
      if (blank) begin
        pos_q  <= 1'b0;
        neg_q  <= 1'b0;
        left_q <= '0;
      end else if (up_evt || dn_evt) begin
        pos_q  <= up_evt;
        neg_q  <= dn_evt;
        left_q <= LOAD;
      end else if (left_q != '0) begin
        left_q <= left_q - 1'b1;
      end else begin
        pos_q <= 1'b0;
        neg_q <= 1'b0;
      end
    end
  end

  assign rise_o = pos_q && !blank;
  assign fall_o = neg_q && !blank;

  AST_PN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pos_q && neg_q)); // R4
  AST_BLANK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    blank |=> (!pos_q && !neg_q)); // R9
  AST_RISE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pos_q) |-> $past(cmd)); // R3
endmodule

// File: rtl/gate_pulse_tx.sv
module gate_pulse_tx #(
  parameter int FILT_W    = 6,
  parameter int DEAD_W    = 4,
  parameter int PULSE_CYC = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_a,
  input  logic              cmd_b,
  input  logic              uv_lock,
  input  logic              ov_lock,
  input  logic              conv_startup,
  input  logic [FILT_W-1:0] filt_len,
  input  logic [DEAD_W-1:0] dead_len,
  output logic              txa_rise,
  output logic              txa_fall,
  output logic              txb_rise,
  output logic              txb_fall
);
  localparam int NCH = 2;

  logic [NCH-1:0] raw;
  logic [NCH-1:0] filt;
  logic [NCH-1:0] cond;
  logic [NCH-1:0] rise_v;
  logic [NCH-1:0] fall_v;
  logic           hold;

  assign raw  = {cmd_b, cmd_a};
  assign hold = uv_lock || ov_lock || conv_startup;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    gpt_glitch_filter #(.CW(FILT_W)) filt_i (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw[ch]),
      .len  (filt_len),
      .dout (filt[ch])
    );
    gpt_edge_pulser #(.PULSE_CYC(PULSE_CYC)) puls_i (
      .clk   (clk),
      .rst_n (rst_n),
      .cmd   (cond[ch]),
      .blank (conv_startup),
      .rise_o(rise_v[ch]),
      .fall_o(fall_v[ch])
    );
  end

  gpt_interlock_dead #(.DW(DEAD_W)) ild_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .fa      (filt[0]),
    .fb      (filt[1]),
    .hold    (hold),
    .dead_len(dead_len),
    .oa      (cond[0]),
    .ob      (cond[1])
  );

  assign txa_rise = rise_v[0];
  assign txa_fall = fall_v[0];
  assign txb_rise = rise_v[1];
  assign txb_fall = fall_v[1];

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !(txa_rise || txa_fall || txb_rise || txb_fall)); // R10
endmodule

// File: tb/gate_pulse_tx_tb_top.sv
module gate_pulse_tx_tb_top;
  localparam int P = 20;

  logic clk = 0;
  logic rst_n = 0;
  logic cmd_a = 0, cmd_b = 0, uv_lock = 0, ov_lock = 0, conv_startup = 0;
  logic [5:0] filt_len = 6'd4;
  logic [3:0] dead_len = 4'd2;
  logic txa_rise, txa_fall, txb_rise, txb_fall;

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  int starts [4];
  int highs [4];
  int tstart [4];
  logic [3:0] prev_o = '0;
  int excl_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gate_pulse_tx dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_a(cmd_a), .cmd_b(cmd_b),
    .uv_lock(uv_lock), .ov_lock(ov_lock), .conv_startup(conv_startup),
    .filt_len(filt_len), .dead_len(dead_len),
    .txa_rise(txa_rise), .txa_fall(txa_fall),
    .txb_rise(txb_rise), .txb_fall(txb_fall)
  );

  // index 0: A rise, 1: A fall, 2: B rise, 3: B fall
  always @(negedge clk) begin
    logic [3:0] o;
    o = {txb_fall, txb_rise, txa_fall, txa_rise};
    cyc++;
    for (int i = 0; i < 4; i++) begin
      if (o[i]) highs[i]++;
      if (o[i] && !prev_o[i]) begin
        starts[i]++;
        tstart[i] = cyc;
      end
    end
    if ((o[0] && o[1]) || (o[2] && o[3])) excl_bad++;
    prev_o = o;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr();
    for (int i = 0; i < 4; i++) begin
      starts[i] = 0;
      highs[i] = 0;
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic first_rise(input int sel, output int k);
    k = -1;
    for (int i = 1; i <= 100; i++) begin
      @(negedge clk);
      if ((sel == 0 && txa_rise) || (sel == 2 && txb_rise)) begin
        k = i;
        break;
      end
    end
  endtask

  initial begin
    int k, fl, exp_pass, el;
    wait_n(3);
    check("R10 reset", int'({txa_rise, txa_fall, txb_rise, txb_fall}), 0);
    rst_n = 1;
    wait_n(2);
    check("R10 after reset", int'({txa_rise, txa_fall, txb_rise, txb_fall}), 0);
    wait_n(20);

    // R1 / R2 / R3 / R4 sweep over filter length and command width
    for (int f = 0; f <= 6; f++) begin
      filt_len = 6'(f);
      fl = (f < 1) ? 1 : f;
      for (int w = 1; w <= 8; w++) begin
        clr();
        cmd_a = 1;
        wait_n(w);
        cmd_a = 0;
        wait_n(60);
        exp_pass = (w >= fl) ? 1 : 0;
        check($sformatf("R1/R2 rise count fl=%0d w=%0d", f, w), starts[0], exp_pass);
        check($sformatf("R3 fall count fl=%0d w=%0d", f, w), starts[1], exp_pass);
        check($sformatf("R4 cut rise width fl=%0d w=%0d", f, w), highs[0],
              exp_pass ? ((w < P) ? w : P) : 0);
        check($sformatf("R3 fall width fl=%0d w=%0d", f, w), highs[1], exp_pass * P);
      end
    end

    // R2 latency and R3 full width on a long command
    for (int f = 1; f <= 5; f += 2) begin
      filt_len = 6'(f);
      clr();
      cmd_a = 1;
      first_rise(0, k);
      check($sformatf("R2 latency fl=%0d", f), k, f + 2);
      wait_n(40);
      cmd_a = 0;
      wait_n(60);
      check("R3 rise width", highs[0], P);
      check("R3 fall width", highs[1], P);
    end

    // R5 / R6 dead time sweep: B active, A takes over
    filt_len = 6'd1;
    for (int d = 0; d <= 6; d++) begin
      dead_len = 4'(d);
      clr();
      cmd_b = 1;
      wait_n(40);
      cmd_a = 1;
      wait_n(40);
      cmd_b = 0;
      wait_n(1);
      cmd_a = 0;
      wait_n(60);
      el = tstart[0] - tstart[3];
      check($sformatf("R6 dead gap d=%0d", d), el, d + 1);
      check($sformatf("R5 single B rise d=%0d", d), starts[2], 1);
    end

    // R7 no added delay after a long gap
    dead_len = 4'd5;
    cmd_a = 1;
    wait_n(30);
    cmd_a = 0;
    wait_n(30);
    cmd_b = 1;
    first_rise(2, k);
    check("R7 no extra delay", k, 3);
    wait_n(30);
    cmd_b = 0;
    wait_n(40);

    // R8 lockouts
    filt_len = 6'd2;
    dead_len = 4'd1;
    cmd_a = 1;
    wait_n(40);
    clr();
    uv_lock = 1;
    wait_n(10);
    check("R8 uv fall pulse", starts[1], 1);
    cmd_b = 1;
    wait_n(30);
    check("R8 uv no B rise", starts[2], 0);
    check("R8 uv no A rise", starts[0], 0);
    cmd_b = 0;
    wait_n(10);
    clr();
    uv_lock = 0;
    wait_n(40);
    check("R8 resend after uv", starts[0], 1);
    clr();
    ov_lock = 1;
    wait_n(30);
    check("R8 ov fall pulse", starts[1], 1);
    ov_lock = 0;
    wait_n(30);
    cmd_a = 0;
    wait_n(40);

    // R9 startup blanking
    conv_startup = 1;
    @(negedge clk);
    clr();
    cmd_a = 1;
    wait_n(30);
    cmd_a = 0;
    wait_n(30);
    cmd_a = 1;
    wait_n(30);
    check("R9 quiet A rise", highs[0], 0);
    check("R9 quiet all", highs[1] + highs[2] + highs[3], 0);
    conv_startup = 0;
    wait_n(40);
    check("R9 rise after startup", starts[0], 1);
    check("R9 rise width after startup", highs[0], P);
    cmd_a = 0;
    wait_n(40);

    check("R4 rise/fall exclusive", excl_bad, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule